// File: doc/BRIEF.md
# UART Control and Status Register File

This block is the byte-wide, memory-mapped register front end of an asynchronous serial port. Software reaches one status register, two control registers, a 12-bit baud divisor held in a low and a high byte, and a data register. On the receive side the block keeps a one-byte holding buffer that a serial back end fills over a valid/ready byte stream. On the transmit side it forwards each accepted data write to the back end as a one-cycle valid pulse. Three level interrupts report receive complete, transmit complete and data register empty.

A small state machine tracks the holding buffer. It has two states, `RXB_EMPTY` and `RXB_FULL`. Three transitions connect them: *accept* (EMPTY to FULL, when a byte arrives while the receiver is enabled), *pop* (FULL to EMPTY, on a data-register read with the receiver enabled) and *flush* (any state to EMPTY, on a control-B write that clears the receiver enable). Flush wins over accept, and accept wins over pop. Received bytes are masked to the configured character width when they are read. A power-reduction input holds the whole block in its reset state and blocks all access while it is high.

Top module: `uart_csr_regfile`

## Requirements
- R1: After reset, status reads 0x20, control B reads 0x00, control C reads 0x06, both baud bytes read 0x00, the receive buffer is empty and all three interrupt outputs are low.
- R2: Offset 0 is status. Bit 7 is the receive-complete flag, bit 6 the transmit-complete flag and bit 5 the data-empty flag. A write changes only bits 6, 1 and 0. Writing 1 to bit 6 clears the transmit-complete flag and drops its interrupt.
- R3: Offset 1 is control B. Bit 7 enables the receive interrupt, bit 6 the transmit interrupt and bit 5 the data-empty interrupt. Bit 4 enables the receiver, bit 3 enables the transmitter and bit 2 is the high character-size bit. Bit 1 is read-only. Writing 0 to bit 4 empties the receive buffer.
- R4: After every control B write, each interrupt output equals its enable bit ANDed with its status flag.
- R5: Offset 4 holds the low baud byte (8 bits). Offset 5 stores only its low 4 bits and reads the upper 4 as 0.
- R6: Offset 2 is control C, and its bits 2:1 are the low character-size bits. Code = {B[2], C[2:1]}. Codes 0 to 3 mask received data to 5, 6, 7 and 8 bits. Code 7 gives 8 bits. Codes 4 to 6 leave the mask unchanged. The mask is updated on each write to B or C.
- R7: A byte is accepted (rx_ready high) only when the receiver is enabled and the buffer is empty. Acceptance sets the receive-complete flag and raises the receive interrupt if that interrupt is enabled.
- R8: A read of offset 6 with the receiver disabled returns 0 and changes nothing. Otherwise it returns the masked byte, or 0 if the buffer is empty. It then empties the buffer, clears the receive-complete flag and drops the receive interrupt.
- R9: A write to offset 6 is ignored while the transmitter is disabled. Otherwise the byte appears on tx_data with tx_valid high for exactly one cycle, the transmit-complete and data-empty flags are set, and the data-empty interrupt rises if enabled. If the transmit interrupt is enabled, it rises and the transmit-complete flag is cleared instead.
- R10: While pwr_off is high, reads return 0 and writes are ignored. Asserting pwr_off restores the R1 state.
- R11: Offsets 3 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_off | input | 1 | Power-reduction: hold in reset, block access |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Buffer can take a byte |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_data | output | 8 | Transmit byte |
| irq_rx_done | output | 1 | Receive-complete interrupt |
| irq_tx_done | output | 1 | Transmit-complete interrupt |
| irq_tx_empty | output | 1 | Data-register-empty interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a 12-bit baud divisor and a 3-bit offset. With an 8-bit path, all four character widths (5 to 8 bits) give distinct read masks, and the reserved size codes can be shown to hold the previous mask. The 12-bit divisor leaves four upper bits in the high byte whose truncation is visible on readback. The 3-bit offset leaves two holes, 3 and 7, that can be probed. Each scenario starts from a power-reduction cycle, so the restore path is exercised repeatedly.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
    localparam int OFF_STA  = 0;
    localparam int OFF_CTLB = 1;
    localparam int OFF_CTLC = 2;
    localparam int OFF_BDL  = 4;
    localparam int OFF_BDH  = 5;
    localparam int OFF_DATA = 6;

    localparam int F_RXC  = 7;
    localparam int F_TXC  = 6;
    localparam int F_DRE  = 5;
    localparam int E_RXIE = 7;
    localparam int E_TXIE = 6;
    localparam int E_DRIE = 5;
    localparam int E_RXEN = 4;
    localparam int E_TXEN = 3;
    localparam int E_SZ2  = 2;

    localparam logic [7:0] STA_RST    = 8'h20;
    localparam logic [7:0] CTLB_RST   = 8'h00;
    localparam logic [7:0] CTLC_RST   = 8'h06;
    localparam logic [7:0] STA_WMASK  = 8'h43;
    localparam logic [7:0] CTLB_WMASK = 8'hFD;

    typedef enum logic {RXB_EMPTY, RXB_FULL} rxb_state_e;
endpackage

// File: rtl/uart_csr_rxbuf.sv
module uart_csr_rxbuf
    import uart_csr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rx_en,
    input  logic              flush,
    input  logic              pop,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              taken,
    output logic              full,
    output logic [DATA_W-1:0] data_q
);
    rxb_state_e state, state_n;
    logic accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= RXB_EMPTY;
        else if (clr)    state <= RXB_EMPTY;
        else             state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            RXB_EMPTY: if (!flush && accept)  state_n = RXB_FULL;
            RXB_FULL:  if (flush || pop)      state_n = RXB_EMPTY;
            default:   state_n = RXB_EMPTY;
        endcase
    end

    always_comb begin
        in_ready = (state == RXB_EMPTY) && rx_en && !clr;
        accept   = in_valid && in_ready;
        taken    = accept && !flush;
        full     = (state == RXB_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_q <= '0;
        else if (taken)  data_q <= in_data;
    end

    a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !full);
    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !flush && !pop && !clr) |=> (full && $stable(data_q)));
endmodule

// File: rtl/uart_csr_charmask.sv
module uart_csr_charmask #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [2:0]        code,
    output logic [DATA_W-1:0] mask
);
    localparam logic [DATA_W-1:0] ONES = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mask <= ONES;
        else if (clr)    mask <= ONES;
        else if (upd) begin
            case (code)
                3'd0, 3'd1, 3'd2, 3'd3: mask <= ONES >> (2'd3 - code[1:0]);
                3'd7:                   mask <= ONES;
                default:                mask <= mask;
            endcase
        end
    end

    a_r6_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && code inside {3'd4, 3'd5, 3'd6}) |=> $stable(mask));
endmodule

// File: rtl/uart_csr_txport.sv
module uart_csr_txport #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] byte_in,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (clr) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= load;
            if (load) tx_data <= byte_in;
        end
    end

    a_r9_pulse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (tx_valid && tx_data == $past(byte_in)));
    a_r9_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !load) |=> !tx_valid);
endmodule

// File: rtl/uart_csr_regfile.sv
module uart_csr_regfile
    import uart_csr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BAUD_W = 12,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_off,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              irq_rx_done,
    output logic              irq_tx_done,
    output logic              irq_tx_empty
);
    localparam int HI_W = BAUD_W - DATA_W;
    localparam logic [ADDR_W-1:0] A_STA  = ADDR_W'(OFF_STA);
    localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(OFF_CTLB);
    localparam logic [ADDR_W-1:0] A_CTLC = ADDR_W'(OFF_CTLC);
    localparam logic [ADDR_W-1:0] A_BDL  = ADDR_W'(OFF_BDL);
    localparam logic [ADDR_W-1:0] A_BDH  = ADDR_W'(OFF_BDH);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);

    logic [7:0] sta, ctlb, ctlc, sta_n, ctlb_n, ctlc_n;
    logic [DATA_W-1:0] baud_lo, baud_lo_n;
    logic [HI_W-1:0]   baud_hi, baud_hi_n;
    logic irq_rx, irq_tx, irq_dre, irq_rx_n, irq_tx_n, irq_dre_n;

    logic wr_ok, rd_ok, wr_b, wr_c, wr_dat, rd_dat;
    logic rx_en, tx_en, flush, pop, taken, full, tx_load, mask_upd;
    logic [2:0] size_code;
    logic [DATA_W-1:0] rx_q, rx_mask;

    always_comb begin
        wr_ok    = bus_wr && !pwr_off;
        rd_ok    = bus_rd && !pwr_off;
        wr_b     = wr_ok && bus_addr == A_CTLB;
        wr_c     = wr_ok && bus_addr == A_CTLC;
        wr_dat   = wr_ok && bus_addr == A_DATA;
        rd_dat   = rd_ok && bus_addr == A_DATA;
        rx_en    = ctlb[E_RXEN];
        tx_en    = ctlb[E_TXEN];
        flush    = wr_b && !bus_wdata[E_RXEN];
        pop      = rd_dat && rx_en;
        tx_load  = wr_dat && tx_en;
        mask_upd = wr_b || wr_c;
        size_code = wr_b ? {bus_wdata[E_SZ2], ctlc[2:1]} : {ctlb[E_SZ2], bus_wdata[2:1]};
    end

    uart_csr_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
        .clk(clk), .rst_n(rst_n), .clr(pwr_off), .rx_en(rx_en), .flush(flush),
        .pop(pop), .in_valid(rx_valid), .in_data(rx_data), .in_ready(rx_ready),
        .taken(taken), .full(full), .data_q(rx_q));

    uart_csr_charmask #(.DATA_W(DATA_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .clr(pwr_off), .upd(mask_upd),
        .code(size_code), .mask(rx_mask));

    uart_csr_txport #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(pwr_off), .load(tx_load),
        .byte_in(bus_wdata), .tx_valid(tx_valid), .tx_data(tx_data));

    // Next-state of the register file
    always_comb begin
        sta_n = sta;  ctlb_n = ctlb;  ctlc_n = ctlc;
        baud_lo_n = baud_lo;  baud_hi_n = baud_hi;
        irq_rx_n = irq_rx;  irq_tx_n = irq_tx;  irq_dre_n = irq_dre;
        if (taken) begin
            sta_n[F_RXC] = 1'b1;
            if (ctlb[E_RXIE]) irq_rx_n = 1'b1;
        end else if (pop) begin
            sta_n[F_RXC] = 1'b0;
            irq_rx_n     = 1'b0;
        end
        if (wr_ok) begin
            case (bus_addr)
                A_STA: begin
                    sta_n = (bus_wdata & STA_WMASK) | (sta_n & ~STA_WMASK);
                    if (bus_wdata[F_TXC]) begin
                        sta_n[F_TXC] = 1'b0;
                        irq_tx_n     = 1'b0;
                    end
                end
                A_CTLB: begin
                    ctlb_n    = (bus_wdata & CTLB_WMASK) | (ctlb & ~CTLB_WMASK);
                    irq_rx_n  = bus_wdata[E_RXIE] && sta_n[F_RXC];
                    irq_tx_n  = bus_wdata[E_TXIE] && sta_n[F_TXC];
                    irq_dre_n = bus_wdata[E_DRIE] && sta_n[F_DRE];
                end
                A_CTLC: ctlc_n    = bus_wdata;
                A_BDL:  baud_lo_n = bus_wdata;
                A_BDH:  baud_hi_n = bus_wdata[HI_W-1:0];
                A_DATA: if (tx_en) begin
                    sta_n[F_TXC] = 1'b1;
                    sta_n[F_DRE] = 1'b1;
                    if (ctlb[E_DRIE]) irq_dre_n = 1'b1;
                    if (ctlb[E_TXIE]) begin
                        irq_tx_n     = 1'b1;
                        sta_n[F_TXC] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || pwr_off) begin
            sta <= STA_RST;  ctlb <= CTLB_RST;  ctlc <= CTLC_RST;
            baud_lo <= '0;   baud_hi <= '0;
            irq_rx <= 1'b0;  irq_tx <= 1'b0;    irq_dre <= 1'b0;
        end else begin
            sta <= sta_n;    ctlb <= ctlb_n;    ctlc <= ctlc_n;
            baud_lo <= baud_lo_n;  baud_hi <= baud_hi_n;
            irq_rx <= irq_rx_n;    irq_tx <= irq_tx_n;  irq_dre <= irq_dre_n;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (bus_addr)
                A_STA:  bus_rdata = sta;
                A_CTLB: bus_rdata = ctlb;
                A_CTLC: bus_rdata = ctlc;
                A_BDL:  bus_rdata = baud_lo;
                A_BDH:  bus_rdata = {{(DATA_W-HI_W){1'b0}}, baud_hi};
                A_DATA: bus_rdata = (rx_en && full) ? (rx_q & rx_mask) : '0;
                default: bus_rdata = '0;
            endcase
        end
        irq_rx_done  = irq_rx;
        irq_tx_done  = irq_tx;
        irq_tx_empty = irq_dre;
    end

    a_r10_power_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off |=> (sta == STA_RST && ctlb == CTLB_RST && !irq_rx_done && !irq_tx_done && !irq_tx_empty));
    a_r5_baud_high_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !pwr_off && bus_addr == A_BDH) |=> (baud_hi == $past(bus_wdata[HI_W-1:0])));
    a_r4_dre_recompute: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && !taken) |=> (irq_tx_empty == ($past(bus_wdata[E_DRIE]) && sta[F_DRE])));
    a_r8_read_drops_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dat && rx_en && !bus_wr && !(rx_valid && rx_ready)) |=> (!irq_rx_done && !sta[F_RXC]));
endmodule

// File: tb/tb_uart_csr_regfile.sv
module tb_uart_csr_regfile;
    logic clk = 1'b0, rst_n = 1'b0, pwr_off = 1'b0;
    logic [2:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, rx_valid = 1'b0;
    logic [7:0] bus_wdata = '0, rx_data = '0, bus_rdata, tx_data;
    logic rx_ready, tx_valid, irq_rx_done, irq_tx_done, irq_tx_empty;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    uart_csr_regfile dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, output logic acc);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        #1 acc = rx_ready;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pcycle();
        @(negedge clk); pwr_off = 1'b1;
        @(negedge clk); pwr_off = 1'b0;
    endtask

    function automatic logic [7:0] irqs();
        return {5'b0, irq_rx_done, irq_tx_done, irq_tx_empty};
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        rd(0, d); chk("R1 status", d, 8'h20);
        rd(1, d); chk("R1 ctlB", d, 8'h00);
        rd(2, d); chk("R1 ctlC", d, 8'h06);
        rd(4, d); chk("R1 baud lo", d, 8'h00);
        rd(5, d); chk("R1 baud hi", d, 8'h00);
        chk("R1 irqs", irqs(), 8'h00);
        chk("R1 rx_ready", {7'b0, rx_ready}, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] d;
        pcycle();
        wr(0, 8'hFF); rd(0, d); chk("R2 status write mask", d, 8'h23);
        wr(0, 8'h00); rd(0, d); chk("R2 status write zero", d, 8'h20);
        wr(1, 8'h08); wr(6, 8'h11); rd(0, d); chk("R2 TXC set by tx", d, 8'h60);
        wr(0, 8'h40); rd(0, d); chk("R2 TXC write-one clear", d, 8'h20);
    endtask

    task automatic t_ctlb();
        logic [7:0] d; logic acc;
        pcycle();
        wr(1, 8'hFF); rd(1, d); chk("R3 ctlB mask", d, 8'hFD);
        wr(1, 8'h00); rd(1, d); chk("R3 ctlB zero", d, 8'h00);
        wr(1, 8'h10); send(8'h55, acc); chk("R3 byte accepted", {7'b0, acc}, 8'h01);
        wr(1, 8'h00); wr(1, 8'h10);
        chk("R3 flush frees buffer", {7'b0, rx_ready}, 8'h01);
        rd(6, d); chk("R3 flushed buffer reads 0", d, 8'h00);
    endtask

    task automatic t_irq();
        logic acc;
        pcycle();
        wr(1, 8'h08); wr(6, 8'h11);
        chk("R4 no irq without enable", irqs(), 8'h00);
        wr(1, 8'h68); chk("R4 tx+dre recomputed high", irqs(), 8'h03);
        wr(1, 8'h08); chk("R4 tx+dre recomputed low", irqs(), 8'h00);
        wr(1, 8'h18); send(8'h42, acc);
        chk("R4 rx irq off while disabled", irqs(), 8'h00);
        wr(1, 8'h98); chk("R4 rx irq recomputed", irqs(), 8'h04);
    endtask

    task automatic t_baud();
        logic [7:0] d;
        pcycle();
        wr(5, 8'hAB); rd(5, d); chk("R5 baud hi nibble", d, 8'h0B);
        wr(4, 8'hCD); rd(4, d); chk("R5 baud lo", d, 8'hCD);
    endtask

    task automatic t_size();
        logic [7:0] d; logic acc;
        pcycle();
        wr(1, 8'h10);
        for (int c = 0; c < 4; c++) begin
            wr(2, 8'(c << 1)); send(8'hFF, acc); rd(6, d);
            chk($sformatf("R6 size code %0d", c), d, 8'((1 << (5 + c)) - 1));
        end
        wr(2, 8'h02);
        wr(1, 8'h14); send(8'hFF, acc); rd(6, d);
        chk("R6 reserved code keeps 6-bit mask", d, 8'h3F);
        wr(2, 8'h06); send(8'hFF, acc); rd(6, d);
        chk("R6 code 7 gives 8 bits", d, 8'hFF);
    endtask

    task automatic t_rx();
        logic [7:0] d; logic acc;
        pcycle();
        send(8'hA5, acc); chk("R7 refused while disabled", {7'b0, acc}, 8'h00);
        wr(1, 8'h90); send(8'hA5, acc);
        chk("R7 accepted", {7'b0, acc}, 8'h01);
        chk("R7 rx irq raised", irqs(), 8'h04);
        rd(0, d); chk("R7 RXC set", d, 8'hA0);
        send(8'h5A, acc); chk("R7 refused while full", {7'b0, acc}, 8'h00);
        rd(6, d); chk("R8 read byte", d, 8'hA5);
        chk("R8 rx irq dropped", irqs(), 8'h00);
        rd(0, d); chk("R8 RXC cleared", d, 8'h20);
        rd(6, d); chk("R8 empty read", d, 8'h00);
        send(8'h3C, acc); wr(1, 8'h80);
        chk("R4 rx irq kept by flag", irqs(), 8'h04);
        rd(6, d); chk("R8 disabled read 0", d, 8'h00);
        chk("R8 disabled read keeps irq", irqs(), 8'h04);
        rd(0, d); chk("R8 disabled read keeps RXC", d, 8'hA0);
    endtask

    task automatic t_tx();
        logic [7:0] d;
        pcycle();
        wr(6, 8'h77); chk("R9 disabled no pulse", {7'b0, tx_valid}, 8'h00);
        rd(0, d); chk("R9 disabled flags unchanged", d, 8'h20);
        wr(1, 8'h28); wr(6, 8'h77);
        chk("R9 pulse valid", {7'b0, tx_valid}, 8'h01);
        chk("R9 pulse data", tx_data, 8'h77);
        chk("R9 dre irq", irqs(), 8'h01);
        @(negedge clk); chk("R9 pulse one cycle", {7'b0, tx_valid}, 8'h00);
        rd(0, d); chk("R9 flags set", d, 8'h60);
        wr(0, 8'h40); wr(1, 8'h48);
        chk("R4 tx irq low with TXC clear", irqs(), 8'h00);
        wr(6, 8'h99); chk("R9 tx irq raised", irqs(), 8'h02);
        rd(0, d); chk("R9 TXC cleared with irq", d, 8'h20);
        wr(0, 8'h40); chk("R2 write-one drops tx irq", irqs(), 8'h00);
    endtask

    task automatic t_power();
        logic [7:0] d; logic acc;
        pcycle();
        wr(1, 8'hB8); wr(4, 8'h5A); send(8'h12, acc); wr(6, 8'h01);
        @(negedge clk); pwr_off = 1'b1;
        rd(1, d); chk("R10 read while off", d, 8'h00);
        wr(4, 8'h99);
        chk("R10 irqs low while off", irqs(), 8'h00);
        @(negedge clk); pwr_off = 1'b0;
        rd(4, d); chk("R10 baud lo reset", d, 8'h00);
        rd(1, d); chk("R10 ctlB reset", d, 8'h00);
        rd(0, d); chk("R10 status reset", d, 8'h20);
        rd(2, d); chk("R10 ctlC reset", d, 8'h06);
        chk("R10 rx_ready low", {7'b0, rx_ready}, 8'h00);
    endtask

    task automatic t_holes();
        logic [7:0] d;
        pcycle();
        wr(3, 8'hFF); wr(7, 8'hFF);
        rd(3, d); chk("R11 offset 3 reads 0", d, 8'h00);
        rd(7, d); chk("R11 offset 7 reads 0", d, 8'h00);
        rd(2, d); chk("R11 ctlC untouched", d, 8'h06);
        rd(0, d); chk("R11 status untouched", d, 8'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset(); t_status(); t_ctlb(); t_irq(); t_baud();
        t_size(); t_rx(); t_tx(); t_power(); t_holes();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule